// File: doc/BRIEF.md
# Matched-Delay Calibration Controller

This block tunes a programmable matched delay line so that it tracks the critical path of a bundled-data pipeline stage. It owns the delay line's control code and a trigger line that feeds both a replica of the critical path and the delay line. A race flip-flop, clocked by the delay-line output and fed by the replica output on its data pin, returns one lead-lag bit per trial. A zero means the line finished first and is too fast. A one means the line is at least as slow as the datapath.

Calibration is a linear search. On a start pulse the code drops to zero, the fastest setting. Each trial holds the trigger low for a programmable settle time and then raises it for a fixed evaluation window. At the end of the window the controller reads the lead-lag bit. It stops on the first one, or it moves to the next code. If the slowest code still reads zero, it keeps that code and flags a failure. The code stays in place until the next start pulse, so the delay line can be used once calibration is over.

Top module: `delay_cal_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `trig`, `done` and `fail` are low and `code` is 0 until the first start pulse.
- R2: A start pulse is accepted in any state. On the next cycle `code` is 0, `done`, `fail` and `trig` are low, and any calibration in progress is abandoned.
- R3: Before each rising edge of `trig`, `trig` is low for exactly `settle_cycles`+1 cycles. The count runs from the start pulse for the first trial and from the fall of the previous trial for the others.
- R4: Each trial holds `trig` high for exactly `EVAL_CYCLES` cycles, and `code` does not change while `trig` is high.
- R5: `lag_sample` is read on the clock edge that ends the high window. If it reads 0 and the code is below its maximum, the next trial uses the code plus one. Trial n after a start therefore uses code n.
- R6: If `lag_sample` reads 1, calibration stops. `done` rises, `fail` stays low and the trial's code is kept. `done` rises (k+1)·(`settle_cycles`+1+`EVAL_CYCLES`) cycles after the start edge, where k is the final code.
- R7: If `lag_sample` reads 0 at the maximum code (all ones, 7 for a 3-bit code), `done` and `fail` rise together and `code` stays at the maximum.
- R8: Once `done` is high, `lag_sample` has no effect. `code`, `done`, `fail` and `trig` hold until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts calibration |
| settle_cycles | input | SETTLE_W | Low time between trials, minus one, in cycles |
| lag_sample | input | 1 | Lead-lag bit from the race flip-flop (1 = delay line not faster than the datapath) |
| trig | output | 1 | Trigger driven to both the replica path and the delay line |
| code | output | CODE_W | Delay-line control code (0 = fastest) |
| done | output | 1 | Calibration finished; code is final |
| fail | output | 1 | Set with done when even the slowest code was too fast |

## Verification
All results are tied to the registered start edge. Clearing is due one cycle after start. The first rising `trig` is due `settle_cycles`+1 cycles later. The trigger's high window lasts `EVAL_CYCLES` cycles. `done` is due exactly (k+1)·(`settle_cycles`+1+`EVAL_CYCLES`) cycles after start. The bench stamps the cycle on which each start is sampled and samples every output on the falling clock edge. It measures run lengths of `trig` low and high, and the elapsed cycles at the rise of `done`, against those figures. A behavioural delay line and race flip-flop supply `lag_sample`, so each expected code follows from the replica delay alone.

// File: rtl/dcal_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the delay calibration controller.
// Assumes: nothing; holds the sequencer state encoding only.
package dcal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // after reset, waiting for start
        ST_SETTLE,  // trigger low, both paths returning to rest
        ST_FIRE,    // trigger high, race in progress
        ST_PASS,    // finished with a good code
        ST_FAIL     // finished at the slowest code without a good sample
    } dcal_state_e;
endpackage

// File: rtl/dcal_window_timer.sv
`timescale 1ns/1ps
// Module: dcal_window_timer
// Down counter that times the settle and evaluation windows.
// Assumes: load has priority; expired is high once the count reaches zero
// and stays high until the next load.
module dcal_window_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new window length or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3/R4: an unloaded, unexpired count falls by exactly one per cycle
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dcal_code_reg.sv
`timescale 1ns/1ps
// Module: dcal_code_reg
// Holds the delay-line control code. It can be cleared to the fastest
// setting or stepped one notch slower.
// Assumes: the sequencer never asks for a step at the maximum code.
module dcal_code_reg #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              at_max
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;

    // Clear wins over step; otherwise the code holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (clear)
            code_q <= '0;
        else if (step)
            code_q <= code_q + 1'b1;
    end

    assign code   = code_q;
    assign at_max = (code_q == CODE_MAX);

    // R5: outside a clear, the code only moves up by one
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && code_q != $past(code_q)) |-> (code_q == $past(code_q) + 1'b1));
    // R7: the sequencer never steps past the slowest code
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && step && !clear) |-> 1'b0);
endmodule

// File: rtl/dcal_seq_fsm.sv
`timescale 1ns/1ps
// Module: dcal_seq_fsm
// Trial sequencer. It alternates settle and fire windows, reads the race
// result when the fire window ends, and decides whether to step, pass or fail.
// Assumes: win_expired comes from a timer loaded through load_settle or
// load_eval; lag_sample is stable by the end of the fire window.
module dcal_seq_fsm
    import dcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic win_expired,
    input  logic lag_sample,
    input  logic code_at_max,
    output logic load_settle,
    output logic load_eval,
    output logic code_clear,
    output logic code_step,
    output logic trig,
    output logic done,
    output logic fail
);
    dcal_state_e state_q, state_d;

    // Next-state and control decode; start overrides every state.
    always_comb begin
        state_d     = state_q;
        load_settle = 1'b0;
        load_eval   = 1'b0;
        code_clear  = 1'b0;
        code_step   = 1'b0;
        if (start) begin
            state_d     = ST_SETTLE;
            load_settle = 1'b1;
            code_clear  = 1'b1;
        end else begin
            case (state_q)
                ST_SETTLE: begin
                    if (win_expired) begin
                        state_d   = ST_FIRE;
                        load_eval = 1'b1;
                    end
                end
                ST_FIRE: begin
                    if (win_expired) begin
                        if (lag_sample)
                            state_d = ST_PASS;
                        else if (code_at_max)
                            state_d = ST_FAIL;
                        else begin
                            state_d     = ST_SETTLE;
                            load_settle = 1'b1;
                            code_step   = 1'b1;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign trig = (state_q == ST_FIRE);
    assign done = (state_q == ST_PASS) || (state_q == ST_FAIL);
    assign fail = (state_q == ST_FAIL);

    // R3: a trial edge only follows a settle window
    a_r3_rise_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> ($past(state_q) == ST_SETTLE));
    // R8: a finished state is left only through start
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail)));
endmodule

// File: rtl/delay_cal_ctrl.sv
`timescale 1ns/1ps
// Module: delay_cal_ctrl (top)
// Calibrates a tunable matched delay line against a critical-path replica
// by a linear search from the fastest code.
// Assumes: lag_sample is the replica output captured by a flip-flop clocked
// by the delay-line output, resolved within EVAL_CYCLES of the trigger edge;
// settle_cycles is held steady during a calibration.
module delay_cal_ctrl #(
    parameter int CODE_W      = 3,
    parameter int SETTLE_W    = 8,
    parameter int EVAL_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                lag_sample,
    output logic                trig,
    output logic [CODE_W-1:0]   code,
    output logic                done,
    output logic                fail
);
    localparam int EVAL_W = $clog2(EVAL_CYCLES + 1);
    localparam int CNT_W  = (SETTLE_W > EVAL_W) ? SETTLE_W : EVAL_W;
    localparam logic [CNT_W-1:0] EVAL_LOAD = CNT_W'(EVAL_CYCLES - 1);

    logic             load_settle, load_eval, win_expired;
    logic             code_clear, code_step, code_at_max;
    logic [CNT_W-1:0] win_len;

    // Pick the window length to load: the fixed fire window or the programmed settle.
    always_comb begin
        win_len = load_eval ? EVAL_LOAD : CNT_W'(settle_cycles);
    end

    dcal_window_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_settle | load_eval),
        .load_val (win_len),
        .expired  (win_expired)
    );

    dcal_code_reg #(.CODE_W(CODE_W)) i_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (code_clear),
        .step   (code_step),
        .code   (code),
        .at_max (code_at_max)
    );

    dcal_seq_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .win_expired (win_expired),
        .lag_sample  (lag_sample),
        .code_at_max (code_at_max),
        .load_settle (load_settle),
        .load_eval   (load_eval),
        .code_clear  (code_clear),
        .code_step   (code_step),
        .trig        (trig),
        .done        (done),
        .fail        (fail)
    );

    // R2: start clears the outcome and returns to the fastest code
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !fail && !trig && code == '0));
    // R4: the code is frozen while the trigger is high
    a_r4_code_stable_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && $past(trig)) |-> (code == $past(code)));
    // R7: a failure is only reported with done at the slowest code
    a_r7_fail_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && code == {CODE_W{1'b1}}));
    // R8: after done, the code holds until start
    a_r8_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(code) && !trig);
endmodule

// File: tb/test_delay_cal_ctrl.sv
`timescale 1ns/1ps
// Bench for delay_cal_ctrl: a behavioural delay line (2+code cycles) and
// replica path (cp_sel cycles) race into a flip-flop that makes lag_sample.
// A driver pushes the expected outcome of each calibration into a queue; a
// monitor pops it at the rise of done and also times the trigger windows.
module test_delay_cal_ctrl;
    localparam int CODE_W   = 3;
    localparam int SETTLE_W = 8;
    localparam int EVAL     = 16;
    localparam int CODE_MAX = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [SETTLE_W-1:0] settle_cycles = 8'd12;
    logic                lag_sample;
    logic                trig;
    logic [CODE_W-1:0]   code;
    logic                done;
    logic                fail;

    always #2 clk = ~clk;

    delay_cal_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W), .EVAL_CYCLES(EVAL)) i_delay_cal_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .lag_sample(lag_sample), .trig(trig), .code(code), .done(done), .fail(fail)
    );

    // ---------------- analog path model ----------------
    logic [11:0] tsr = '0;
    logic        dl_prev = 1'b0;
    logic        lag_q = 1'b0;
    logic        inject = 1'b0;
    int          cp_sel = 2;

    always @(posedge clk) begin
        tsr     <= {tsr[10:0], trig};
        dl_prev <= tsr[2 + int'(code)];
        if (tsr[2 + int'(code)] && !dl_prev)
            lag_q <= tsr[cp_sel];
    end
    assign lag_sample = lag_q ^ inject;

    // ---------------- bookkeeping ----------------
    typedef struct {
        int code;
        bit fail;
        int cycles;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    int unsigned cyc = 0;
    int unsigned start_cyc = 0;
    int          cur_settle = 12;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: pulse start and push the expected outcome from the replica delay.
    task automatic start_cal(int cp, int settle, bit push);
        exp_t e;
        int   k;
        @(negedge clk);
        cp_sel        = cp;
        settle_cycles = SETTLE_W'(settle);
        cur_settle    = settle;
        start         = 1'b1;
        start_cyc     = cyc + 1;
        if (push) begin
            k      = (cp - 2 < 0) ? 0 : cp - 2;
            e.fail = (k > CODE_MAX);
            if (e.fail) k = CODE_MAX;
            e.code   = k;
            e.cycles = (k + 1) * (settle + 1 + EVAL);
            sb_q.push_back(e);
        end
        @(negedge clk);
        start = 1'b0;
        // R2: one cycle after start the outcome is cleared
        check_eq("R2", "done after start", int'(done), 0);
        check_eq("R2", "fail after start", int'(fail), 0);
        check_eq("R2", "code after start", int'(code), 0);
        check_eq("R2", "trig after start", int'(trig), 0);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // ---------------- monitor ----------------
    logic prev_trig = 1'b0;
    logic prev_done = 1'b0;
    int   low_run = 0;
    int   hi_run = 0;
    int   trial = 0;

    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (start) begin
                low_run = 0;
                hi_run  = 0;
                trial   = 0;
            end else begin
                if (trig && !prev_trig) begin
                    check_eq("R3", "trig low run", low_run, cur_settle + 1);
                    check_eq("R5", "code of trial", int'(code), trial);
                    hi_run = 1;
                end else if (trig) begin
                    hi_run++;
                end
                if (!trig && prev_trig) begin
                    check_eq("R4", "trig high run", hi_run, EVAL);
                    trial++;
                    low_run = 1;
                end else if (!trig) begin
                    low_run++;
                end
            end
            if (done && !prev_done) begin
                if (sb_q.size() == 0) begin
                    check_eq("R6", "unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check_eq(e.fail ? "R7" : "R6", "final code", int'(code), e.code);
                    check_eq(e.fail ? "R7" : "R6", "fail flag", int'(fail), int'(e.fail));
                    check_eq("R6", "cycles to done", int'(cyc - start_cyc), e.cycles);
                end
            end
        end
        prev_trig = trig;
        prev_done = done;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int   hold_code;
        logic hold_fail;
        repeat (3) @(negedge clk);
        // R1: reset values
        check_eq("R1", "trig in reset", int'(trig), 0);
        check_eq("R1", "done in reset", int'(done), 0);
        check_eq("R1", "fail in reset", int'(fail), 0);
        check_eq("R1", "code in reset", int'(code), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R1", "trig idle", int'(trig), 0);
        check_eq("R1", "done idle", int'(done), 0);
        check_eq("R1", "code idle", int'(code), 0);

        start_cal(2, 12, 1);  wait_done();   // R6: passes at the first code
        start_cal(5, 12, 1);  wait_done();   // R5/R6: three steps
        start_cal(9, 12, 1);  wait_done();   // R6: passes at the slowest code
        start_cal(10, 12, 1); wait_done();   // R7: never passes
        start_cal(6, 15, 1);  wait_done();   // R3: different settle length

        // R2: restart during the settle window of a run
        start_cal(4, 12, 0);
        repeat (5) @(negedge clk);
        start_cal(4, 12, 1);
        wait_done();

        // R8: lag_sample toggling after done has no effect
        hold_code = int'(code);
        hold_fail = fail;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            inject = ~inject;
            check_eq("R8", "code held", int'(code), hold_code);
            check_eq("R8", "done held", int'(done), 1);
            check_eq("R8", "fail held", int'(fail), int'(hold_fail));
            check_eq("R8", "trig held", int'(trig), 0);
        end
        inject = 1'b0;
        repeat (4) @(negedge clk);

        // R2: restart out of the failed state
        start_cal(10, 10, 1); wait_done();
        start_cal(3, 10, 1);  wait_done();

        repeat (4) @(negedge clk);
        check_eq("R6", "outstanding results", sb_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule